// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Decade Counter

This block counts from 0 to 9 and wraps. The state sits in a five-stage twisted-ring register: the first stage loads the inverse of the last stage, and every other stage copies its lower neighbour. Ten one-hot outputs show the current count. An active-low carry output is low through the upper half of the count, so a following counter can take it as its rising-edge count input. Two count inputs with opposite edge senses arrive asynchronously. The block brings each one to the system clock through a synchronizer chain, then finds its edges.

A count happens on a rising edge of `rise_cnt_i` while `fall_cnt_i` is low. A count also happens on a falling edge of `fall_cnt_i` while `rise_cnt_i` is high. The synchronous reset `rst` and the asynchronous clear `mr` both force count 0. A load port writes any 5-bit pattern into the ring, so a test can start from an illegal code. The ring repairs such codes by itself as counts are applied.

Top module: `jc_decade_counter`

## Requirements
- R1: While `mr` is high, and from the moment it rises with no clock edge needed, `dec_o` equals 10'b0000000001 and `carry_n_o` is 1. A `rst` sampled high gives the same outputs after the clock edge.
- R2: In a legal state exactly one bit of `dec_o` is high. Each count moves that bit from position k to position (k+1) mod 10.
- R3: A rising edge of `rise_cnt_i` while `fall_cnt_i` is low advances the count by one.
- R4: A falling edge of `fall_cnt_i` while `rise_cnt_i` is high advances the count by one.
- R5: These changes leave the outputs unchanged: a rising edge of `fall_cnt_i`, a falling edge of `rise_cnt_i`, a rising edge of `rise_cnt_i` while `fall_cnt_i` is high, and a falling edge of `fall_cnt_i` while `rise_cnt_i` is low.
- R6: `carry_n_o` is 0 in counts 5 to 9 and 1 in counts 0 to 4.
- R7: From any of the 32 ring codes, at most 11 counts bring the ring into the legal ten-state cycle. After that it counts in the normal order.
- R8: A rising edge of `rise_cnt_i` and a falling edge of `fall_cnt_i` in the same cycle give exactly one count.
- R9: When `load_en` is high, the next clock edge writes `load_code` into the ring. Bit i of `load_code` goes to stage i. Load takes priority over a count. In a legal state, count k has ones in bits 0 to k-1 for k from 0 to 5, and ones in bits k-5 to 4 for k from 6 to 9.
- R10: A count shows on the outputs at the third rising clock edge after the input change, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mr | input | 1 | Asynchronous active-high clear to count 0 |
| rise_cnt_i | input | 1 | Count input, counts on its rising edge |
| fall_cnt_i | input | 1 | Count input, counts on its falling edge |
| load_en | input | 1 | Test load strobe for the ring |
| load_code | input | 5 | Ring pattern to load, bit i to stage i |
| dec_o | output | 10 | Decoded one-hot count |
| carry_n_o | output | 1 | Active-low carry, low in counts 5 to 9 |

## Verification
The bench applies each possible level change of the two count inputs, both alone and together. The single-input changes show whether the edge check uses the level of the other input correctly (R3, R4, R5). The change where both inputs move at once shows whether two valid edges in one cycle are merged into one count (R8). The bench loads all 32 ring codes and counts through them, which shows whether the ring repairs illegal codes in time and then keeps to the legal order. Several full wraps, and an asynchronous clear in the middle of a count, check the decoded outputs, the carry and the clear (R1).

// File: rtl/jc_pkg.sv
package jc_pkg;
  // Edge events found on the two synchronized count inputs
  typedef struct packed {
    logic up_rise;   // qualified rising edge on the rising-sense input
    logic dn_fall;   // qualified falling edge on the falling-sense input
  } jc_edges_t;

  localparam int JC_MIN_SYNC = 2;
endpackage

// File: rtl/jc_sync.sv
module jc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/jc_edge_qual.sv
module jc_edge_qual
  import jc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic up_lvl,
  input  logic dn_lvl,
  output logic adv
);
  logic      up_prev, dn_prev;
  jc_edges_t ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_prev <= 1'b0;
      dn_prev <= 1'b0;
    end else begin
      up_prev <= up_lvl;
      dn_prev <= dn_lvl;
    end
  end

  always_comb begin
    ev.up_rise = up_lvl & ~up_prev & ~dn_lvl;
    ev.dn_fall = ~dn_lvl & dn_prev & up_lvl;
  end

  // Both qualified edges in one cycle still give a single count
  assign adv = ev.up_rise | ev.dn_fall;
endmodule

// File: rtl/jc_ring.sv
module jc_ring #(
  parameter int STAGES = 5,
  localparam int NOUT  = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mr,
  input  logic              load_en,
  input  logic [STAGES-1:0] load_code,
  input  logic              adv,
  output logic [NOUT-1:0]   dec_q,
  output logic              carry_n_q
);
  logic [STAGES-1:0] ring_q, ring_d, shifted;
  logic [NOUT-1:0]   circ, dec_d;

  // Twisted shift with repair term on stage 2: a lone 1 in stage 1
  // (zeros in stages 0 and 2) is dropped as it moves up.
  assign shifted[0] = ~ring_q[STAGES-1];
  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_shift
      if (i == 2) begin : g_fix
        assign shifted[i] = ring_q[1] & (ring_q[0] | ring_q[2]);
      end else begin : g_plain
        assign shifted[i] = ring_q[i-1];
      end
    end
  endgenerate

  always_comb begin
    if (load_en)  ring_d = load_code;
    else if (adv) ring_d = shifted;
    else          ring_d = ring_q;
  end

  // Ring plus its complement form a 2*STAGES circle; each output
  // marks the single 1-to-0 boundary of a legal circle.
  generate
    for (genvar j = 0; j < NOUT; j++) begin : g_dec
      if (j < STAGES) begin : g_lo
        assign circ[j] = ring_d[j];
      end else begin : g_hi
        assign circ[j] = ~ring_d[j-STAGES];
      end
      assign dec_d[j] = circ[(j+NOUT-1)%NOUT] & ~circ[j];
    end
  endgenerate

  always_ff @(posedge clk or posedge mr) begin
    if (mr) begin
      ring_q    <= '0;
      dec_q     <= NOUT'(1);
      carry_n_q <= 1'b1;
    end else if (rst) begin
      ring_q    <= '0;
      dec_q     <= NOUT'(1);
      carry_n_q <= 1'b1;
    end else begin
      ring_q    <= ring_d;
      dec_q     <= dec_d;
      carry_n_q <= ~ring_d[STAGES-1];
    end
  end
endmodule

// File: rtl/jc_decade_counter.sv
module jc_decade_counter #(
  parameter int STAGES      = 5,
  parameter int SYNC_STAGES = jc_pkg::JC_MIN_SYNC,
  localparam int NOUT       = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mr,
  input  logic              rise_cnt_i,
  input  logic              fall_cnt_i,
  input  logic              load_en,
  input  logic [STAGES-1:0] load_code,
  output logic [NOUT-1:0]   dec_o,
  output logic              carry_n_o
);
  logic [1:0] lvl;
  logic       adv_w;

  jc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({fall_cnt_i, rise_cnt_i}),
    .q   (lvl)
  );

  jc_edge_qual edge_i (
    .clk    (clk),
    .rst    (rst),
    .up_lvl (lvl[0]),
    .dn_lvl (lvl[1]),
    .adv    (adv_w)
  );

  jc_ring #(.STAGES(STAGES)) ring_i (
    .clk       (clk),
    .rst       (rst),
    .mr        (mr),
    .load_en   (load_en),
    .load_code (load_code),
    .adv       (adv_w),
    .dec_q     (dec_o),
    .carry_n_q (carry_n_o)
  );
endmodule

// File: rtl/jc_decade_counter_chk.sv
module jc_decade_counter_chk #(
  parameter int STAGES = 5,
  localparam int NOUT  = 2 * STAGES
) (
  input logic            clk,
  input logic            rst,
  input logic            mr,
  input logic            load_en,
  input logic            adv,
  input logic [NOUT-1:0] dec_o,
  input logic            carry_n_o
);
  // R1
  mr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mr |-> (dec_o == NOUT'(1) && carry_n_o));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst || mr)
    (!adv && !load_en) |=> ($stable(dec_o) && $stable(carry_n_o)));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst || mr)
    (adv && !load_en && $onehot(dec_o)) |=>
      (dec_o == {$past(dec_o[NOUT-2:0]), $past(dec_o[NOUT-1])}));

  // R6
  carry_chk: assert property (@(posedge clk) disable iff (rst || mr)
    $onehot(dec_o) |-> (carry_n_o == ~|dec_o[NOUT-1:STAGES]));
endmodule

bind jc_decade_counter jc_decade_counter_chk #(.STAGES(STAGES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mr        (mr),
  .load_en   (load_en),
  .adv       (adv_w),
  .dec_o     (dec_o),
  .carry_n_o (carry_n_o)
);

// File: tb/jc_decade_counter_tb.sv
module jc_decade_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mr = 1'b0;
  logic       rise_cnt = 1'b0;
  logic       fall_cnt = 1'b0;
  logic       load_en = 1'b0;
  logic [4:0] load_code = 5'd0;
  logic [9:0] dec_o;
  logic       carry_n_o;

  int checks = 0;
  int errors = 0;
  int exp_k  = 0;

  always #4 clk = ~clk;

  jc_decade_counter dut_i (
    .clk(clk), .rst(rst), .mr(mr), .rise_cnt_i(rise_cnt), .fall_cnt_i(fall_cnt),
    .load_en(load_en), .load_code(load_code), .dec_o(dec_o), .carry_n_o(carry_n_o)
  );

  task automatic chk(input string tag, input int k);
    logic [9:0] e;
    logic       ec;
    e  = 10'd1 << k;
    ec = (k < 5);
    checks++;
    if (dec_o !== e || carry_n_o !== ec) begin
      errors++;
      $display("FAIL %s: dec=%b carry_n=%b expected dec=%b carry_n=%b",
               tag, dec_o, carry_n_o, e, ec);
    end
  endtask

  task automatic set_in(input logic a, input logic b);
    @(negedge clk);
    rise_cnt = a;
    fall_cnt = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_up();
    set_in(1'b1, 1'b0);
    set_in(1'b0, 1'b0);
  endtask

  task automatic do_load(input logic [4:0] c);
    @(negedge clk);
    load_en = 1'b1;
    load_code = c;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_k = 0;
    chk("R1 sync reset", exp_k);
  endtask

  task automatic t_up_count();
    for (int n = 0; n < 25; n++) begin
      set_in(1'b1, 1'b0);
      exp_k = (exp_k + 1) % 10;
      chk("R3 R2 R6 rising-sense count", exp_k);
      set_in(1'b0, 1'b0);
      chk("R5 falling rising-sense input", exp_k);
    end
  endtask

  task automatic t_dn_count();
    set_in(1'b0, 1'b1);
    chk("R5 rise on falling-sense input", exp_k);
    set_in(1'b1, 1'b1);
    chk("R5 rising-sense edge while other high", exp_k);
    for (int n = 0; n < 12; n++) begin
      set_in(1'b1, 1'b0);
      exp_k = (exp_k + 1) % 10;
      chk("R4 falling-sense count", exp_k);
      set_in(1'b1, 1'b1);
      chk("R5 rise on falling-sense input", exp_k);
    end
  endtask

  task automatic t_ignored();
    set_in(1'b0, 1'b1);
    chk("R5 rising-sense input falls", exp_k);
    set_in(1'b0, 1'b0);
    chk("R5 falling edge while rising-sense low", exp_k);
  endtask

  task automatic t_both();
    set_in(1'b0, 1'b1);
    set_in(1'b1, 1'b0);
    exp_k = (exp_k + 1) % 10;
    chk("R8 coincident edges count once", exp_k);
    set_in(1'b0, 1'b0);
    chk("R8 settle", exp_k);
  endtask

  task automatic t_latency();
    int old_k;
    old_k = exp_k;
    @(negedge clk);
    rise_cnt = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 no change at second edge", old_k);
    @(negedge clk);
    exp_k = (exp_k + 1) % 10;
    chk("R10 change at third edge", exp_k);
    set_in(1'b0, 1'b0);
  endtask

  task automatic t_mr();
    while (exp_k != 7) begin
      pulse_up();
      exp_k = (exp_k + 1) % 10;
    end
    chk("R6 count seven", exp_k);
    @(negedge clk);
    #1 mr = 1'b1;
    #1;
    exp_k = 0;
    chk("R1 asynchronous clear", exp_k);
    @(negedge clk);
    chk("R1 clear held", exp_k);
    @(negedge clk);
    mr = 1'b0;
    @(negedge clk);
    chk("R1 after release", exp_k);
    pulse_up();
    exp_k = 1;
    chk("R1 counts after clear", exp_k);
  endtask

  task automatic t_load();
    do_load(5'b11111);
    exp_k = 5;
    chk("R9 load count five", exp_k);
    do_load(5'b00111);
    exp_k = 3;
    chk("R9 load count three", exp_k);
    do_load(5'b11000);
    exp_k = 8;
    chk("R9 load count eight", exp_k);
  endtask

  task automatic t_converge();
    for (int c = 0; c < 32; c++) begin
      int idx;
      do_load(5'(c));
      repeat (11) pulse_up();
      checks++;
      if (!$onehot(dec_o)) begin
        errors++;
        $display("FAIL R7 code %0d: dec=%b expected one-hot", c, dec_o);
      end
      idx = 0;
      for (int b = 0; b < 10; b++) if (dec_o[b]) idx = b;
      for (int s = 0; s < 10; s++) begin
        pulse_up();
        idx = (idx + 1) % 10;
        chk($sformatf("R7 code %0d step %0d", c, s), idx);
      end
    end
    exp_k = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_up_count();
    t_dn_count();
    t_ignored();
    t_both();
    t_latency();
    t_mr();
    t_load();
    t_converge();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule